// File: doc/BRIEF.md
# Synchronized Stream Start/Stop Gate

This block decides, for each of several audio DMA streams, when the stream may fetch memory and when it may move samples over a frame-based serial link. Each stream has a run bit and a ready flag from its DMA or FIFO side. The run bits and a word of per-stream hold bits are written by software. While a stream's hold bit is set, its DMA keeps prefetching but its link traffic is paused. Releasing several hold bits in one word write makes all those streams go live on the same link frame. Setting them again in one write stops them all on the same frame.

Hold-word changes act only at a frame-start strobe, so a stream never joins or leaves the link in the middle of a frame. Clearing a run bit is immediate: both enables drop in the next cycle. An aggregate flag tells software when every held stream reports ready, which means the release write can be issued.

Each stream is driven by a three-state machine. `LN_IDLE` means the run bit is clear. `LN_ARMED` means the run bit is set but the stream is not yet on the link. `LN_LIVE` means the stream is moving samples. The transitions are:
- arm (IDLE→ARMED, the run bit becomes set);
- launch (ARMED→LIVE, at a frame strobe with the hold bit clear);
- park (LIVE→ARMED, at a frame strobe with the hold bit set);
- drop (ARMED or LIVE→IDLE, the run bit becomes clear).

Top module: `stream_sync_gate`

## Requirements
- R1: After reset, all run bits and hold bits are clear, every `dma_fetch_en` and `link_active` bit is 0, and `all_held_ready` is 1.
- R2: Writing a run word sets `dma_fetch_en` to that word in the cycle after the write, whatever the hold bits are.
- R3: While a stream's hold bit is set, its `link_active` stays 0 across any number of frame strobes, even with its run bit set.
- R4: A hold write replaces all hold bits at once. The new value affects `link_active` only at the next frame strobe, and a strobe in the same cycle as the write already uses the new value.
- R5: A stream with run set goes live (`link_active` = 1) in the cycle after a frame strobe at which its hold bit is clear. Streams released by one hold write go live in the same cycle.
- R6: Setting the hold bit of a live stream clears its `link_active` in the cycle after the next frame strobe, while its `dma_fetch_en` stays 1.
- R7: Clearing a stream's run bit clears both its `dma_fetch_en` and its `link_active` in the cycle after the write, regardless of its hold bit or of frame strobes.
- R8: `all_held_ready` is 1 exactly when every stream whose hold bit (as last written) is 1 also has `fifo_ready` = 1. It is 1 when no hold bit is set, and it follows `fifo_ready` combinationally.
- R9: A stream whose hold bit is never set starts alone, at the first frame strobe after the cycle of its run write. A strobe in the same cycle as the run write does not start it.
- R10: Once all run bits and then all hold bits are cleared, the block is back in its reset-like idle state. Further frame strobes leave all outputs at their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at each link frame boundary |
| run_wr_en | input | 1 | Write strobe for the run word |
| run_wr_data | input | NUM_STREAMS | New run word, bit i for stream i |
| hold_wr_en | input | 1 | Write strobe for the shared hold word |
| hold_wr_data | input | NUM_STREAMS | New hold word, bit i for stream i |
| fifo_ready | input | NUM_STREAMS | Per-stream ready flag from the DMA/FIFO side |
| dma_fetch_en | output | NUM_STREAMS | Per-stream DMA fetch enable |
| link_active | output | NUM_STREAMS | Per-stream link transmit/capture enable and status |
| all_held_ready | output | 1 | Every held stream reports ready |

## Verification
Timing of each output:
- `dma_fetch_en` follows a run write one cycle later.
- `link_active` changes one cycle after the frame strobe that launches or parks a stream, or one cycle after a run-clear write.
- `all_held_ready` is combinational from the stored hold word and `fifo_ready`.

The bench drives every input at a falling edge and holds it for one full cycle. Register-driven outputs are checked at the next falling edge, after exactly one rising edge. `all_held_ready` is checked one nanosecond after `fifo_ready` changes, with no clock edge in between. Hold writes made without a strobe are checked before any strobe, so a premature change to the link enables is seen.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_ARMED = 2'd1,
        LN_LIVE  = 2'd2
    } lane_state_t;
endpackage

// File: rtl/ssg_ctrl_regs.sv
module ssg_ctrl_regs #(
    parameter int NUM_STREAMS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_wr_en,
    input  logic [NUM_STREAMS-1:0] run_wr_data,
    input  logic                   hold_wr_en,
    input  logic [NUM_STREAMS-1:0] hold_wr_data,
    output logic [NUM_STREAMS-1:0] run_q,
    output logic [NUM_STREAMS-1:0] run_nxt,
    output logic [NUM_STREAMS-1:0] hold_q,
    output logic [NUM_STREAMS-1:0] hold_nxt
);
    always_comb begin
        run_nxt  = run_wr_en  ? run_wr_data  : run_q;
        hold_nxt = hold_wr_en ? hold_wr_data : hold_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            hold_q <= '0;
        end else begin
            run_q  <= run_nxt;
            hold_q <= hold_nxt;
        end
    end

    AST_HOLD_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_wr_en |=> $stable(hold_q)); // R4
    AST_RUN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_wr_en |=> $stable(run_q)); // R2
endmodule

// File: rtl/ssg_lane_fsm.sv
module ssg_lane_fsm
    import ssg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic run_q,
    input  logic run_nxt,
    input  logic hold_nxt,
    output logic link_on
);
    lane_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE:  if (run_nxt) state_d = LN_ARMED;
            LN_ARMED: begin
                if (!run_nxt)                     state_d = LN_IDLE;
                else if (frame_start && !hold_nxt) state_d = LN_LIVE;
            end
            LN_LIVE: begin
                if (!run_nxt)                     state_d = LN_IDLE;
                else if (frame_start && hold_nxt)  state_d = LN_ARMED;
            end
            default: state_d = LN_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LN_LIVE: link_on = 1'b1;
            default: link_on = 1'b0;
        endcase
    end

    AST_LIVE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        link_on |-> run_q); // R7
    AST_START_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_on) |-> $past(frame_start)); // R5
    AST_STOP_ON_FRAME_OR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_on) |-> ($past(frame_start) || !run_q)); // R6
    AST_NO_LIVE_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && hold_nxt) |=> !link_on); // R3
endmodule

// File: rtl/ssg_ready_agg.sv
module ssg_ready_agg #(
    parameter int NUM_STREAMS = 4
) (
    input  logic [NUM_STREAMS-1:0] hold_q,
    input  logic [NUM_STREAMS-1:0] fifo_ready,
    output logic                   all_ready
);
    logic [NUM_STREAMS-1:0] lane_ok;

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_ok
        assign lane_ok[i] = !hold_q[i] || fifo_ready[i];
    end

    assign all_ready = &lane_ok;
endmodule

// File: rtl/stream_sync_gate.sv
module stream_sync_gate #(
    parameter int NUM_STREAMS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic                   run_wr_en,
    input  logic [NUM_STREAMS-1:0] run_wr_data,
    input  logic                   hold_wr_en,
    input  logic [NUM_STREAMS-1:0] hold_wr_data,
    input  logic [NUM_STREAMS-1:0] fifo_ready,
    output logic [NUM_STREAMS-1:0] dma_fetch_en,
    output logic [NUM_STREAMS-1:0] link_active,
    output logic                   all_held_ready
);
    logic [NUM_STREAMS-1:0] run_q, run_nxt, hold_q, hold_nxt;

    ssg_ctrl_regs #(.NUM_STREAMS(NUM_STREAMS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_wr_en    (run_wr_en),
        .run_wr_data  (run_wr_data),
        .hold_wr_en   (hold_wr_en),
        .hold_wr_data (hold_wr_data),
        .run_q        (run_q),
        .run_nxt      (run_nxt),
        .hold_q       (hold_q),
        .hold_nxt     (hold_nxt)
    );

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_lane
        ssg_lane_fsm u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .run_q       (run_q[i]),
            .run_nxt     (run_nxt[i]),
            .hold_nxt    (hold_nxt[i]),
            .link_on     (link_active[i])
        );
    end

    ssg_ready_agg #(.NUM_STREAMS(NUM_STREAMS)) u_agg (
        .hold_q     (hold_q),
        .fifo_ready (fifo_ready),
        .all_ready  (all_held_ready)
    );

    assign dma_fetch_en = run_q;

    AST_FETCH_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (run_wr_en && !run_wr_data[0]) |=> (!dma_fetch_en[0] && !link_active[0])); // R7
    AST_FETCH_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        run_wr_en |=> (dma_fetch_en == $past(run_wr_data))); // R2
endmodule

// File: tb/tb_stream_sync_gate.sv
module tb_stream_sync_gate;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_start = 1'b0;
    logic         run_wr_en = 1'b0;
    logic [N-1:0] run_wr_data = '0;
    logic         hold_wr_en = 1'b0;
    logic [N-1:0] hold_wr_data = '0;
    logic [N-1:0] fifo_ready = '0;
    logic [N-1:0] dma_fetch_en, link_active;
    logic         all_held_ready;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    stream_sync_gate #(.NUM_STREAMS(N)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .run_wr_en(run_wr_en), .run_wr_data(run_wr_data),
        .hold_wr_en(hold_wr_en), .hold_wr_data(hold_wr_data),
        .fifo_ready(fifo_ready), .dma_fetch_en(dma_fetch_en),
        .link_active(link_active), .all_held_ready(all_held_ready)
    );

    task automatic chk(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_run(input logic [N-1:0] d, input logic with_frame);
        run_wr_en = 1'b1; run_wr_data = d; frame_start = with_frame;
        cyc();
        run_wr_en = 1'b0; frame_start = 1'b0;
    endtask

    task automatic wr_hold(input logic [N-1:0] d, input logic with_frame);
        hold_wr_en = 1'b1; hold_wr_data = d; frame_start = with_frame;
        cyc();
        hold_wr_en = 1'b0; frame_start = 1'b0;
    endtask

    task automatic frame();
        frame_start = 1'b1;
        cyc();
        frame_start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "dma_fetch_en", dma_fetch_en, '0);
        chk("R1", "link_active", link_active, '0);
        chk("R1", "all_held_ready", {3'b0, all_held_ready}, 4'b0001);
    endtask

    task automatic t_sync_start();
        wr_hold(4'b0011, 1'b0);
        chk("R8", "all_held_ready none ready", {3'b0, all_held_ready}, 4'b0000);
        wr_run(4'b0011, 1'b0);
        chk("R2", "dma_fetch_en with hold set", dma_fetch_en, 4'b0011);
        frame();
        frame();
        chk("R3", "link_active while held", link_active, 4'b0000);
        fifo_ready = 4'b0001; #1;
        chk("R8", "all_held_ready partial", {3'b0, all_held_ready}, 4'b0000);
        fifo_ready = 4'b0111; #1;
        chk("R8", "all_held_ready all held ready", {3'b0, all_held_ready}, 4'b0001);
        @(negedge clk);
        wr_hold(4'b0000, 1'b0);
        cyc();
        chk("R4", "link_active before strobe", link_active, 4'b0000);
        frame();
        chk("R5", "link_active released together", link_active, 4'b0011);
    endtask

    task automatic t_sync_stop();
        wr_hold(4'b0011, 1'b0);
        chk("R4", "link_active kept until strobe", link_active, 4'b0011);
        frame();
        chk("R6", "link_active parked", link_active, 4'b0000);
        chk("R6", "dma_fetch_en kept", dma_fetch_en, 4'b0011);
        wr_run(4'b0000, 1'b0);
        chk("R7", "dma_fetch_en after run clear", dma_fetch_en, 4'b0000);
        wr_hold(4'b0000, 1'b0);
        frame();
        frame();
        chk("R10", "dma_fetch_en idle", dma_fetch_en, 4'b0000);
        chk("R10", "link_active idle", link_active, 4'b0000);
        fifo_ready = '0; #1;
        chk("R10", "all_held_ready idle", {3'b0, all_held_ready}, 4'b0001);
        @(negedge clk);
    endtask

    task automatic t_single();
        wr_run(4'b0100, 1'b1);
        chk("R9", "dma_fetch_en alone", dma_fetch_en, 4'b0100);
        chk("R9", "no start on same-cycle strobe", link_active, 4'b0000);
        frame();
        chk("R9", "link_active alone", link_active, 4'b0100);
        wr_run(4'b0000, 1'b0);
        chk("R7", "link_active after run clear", link_active, 4'b0000);
        chk("R7", "dma_fetch_en after run clear", dma_fetch_en, 4'b0000);
    endtask

    task automatic t_same_cycle();
        wr_run(4'b1000, 1'b0);
        frame();
        chk("R9", "stream 3 live", link_active, 4'b1000);
        wr_hold(4'b1000, 1'b1);
        chk("R4", "hold with same-cycle strobe parks", link_active, 4'b0000);
        wr_hold(4'b0000, 1'b1);
        chk("R4", "release with same-cycle strobe", link_active, 4'b1000);
        wr_hold(4'b1000, 1'b0);
        wr_run(4'b0000, 1'b1);
        chk("R7", "run clear beats strobe", link_active, 4'b0000);
        wr_hold(4'b0000, 1'b0);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync_start();
        t_sync_stop();
        t_single();
        t_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule